// File: doc/BRIEF.md
# Control Transfer Stage Tracker

This block watches the packet-level events of a USB endpoint-0 control transfer and reports which stage the transfer is in as a 3-bit code. It receives single-cycle pulses for SETUP, IN and OUT tokens and for ACK handshakes in both directions. Alongside these pulses it receives qualifiers describing the request and the last received packet. When the host breaks the expected order of packets, the block moves to an error stage and forces the endpoint-0 handshake to stall.

A sticky stage-change interrupt flag marks the points at which firmware must act. These are the end of the setup stage, entry into either status stage, the end of the transfer and, when enabled, a sequence error. With error reporting enabled, the error code is frozen until firmware clears the flag. This lets firmware inspect the failure before a new SETUP can overwrite it.

Top module: `ctrl_xfer_tracker`

## Requirements
- R1: The stage code takes these values: 000 idle/setup, 001 read data, 010 read status, 011 write data, 100 write status, 101 no-data status, 110 sequence error. The value 111 is never output.
- R2: A synchronous active-high reset sets the stage code to 000 and clears the interrupt flag and the stall.
- R3: A SETUP token, when no error is locked, returns the stage to 000 and drops the stall. If several pulses arrive in one cycle, they are taken in this priority: SETUP, OUT, IN, ACK sent, ACK received. The next ACK sent completes the setup stage and raises the interrupt. The stage then becomes 001 if the request is device-to-host, 101 if host-to-device with zero wLength, and 011 otherwise. ACK sent in stage 000 with no pending SETUP is ignored.
- R4: In stage 001, ACK received marks data as sent. An OUT token after that moves to 010 and raises the interrupt. An OUT token before any data was sent is a sequence error. In 010, ACK received returns to 000 and raises the interrupt.
- R5: In stage 010, an IN token is a sequence error, and so is an OUT token whose packet is not zero-length.
- R6: In stage 011, any number of OUT packets within the size limit are accepted, and ACK sent marks the data as acknowledged. An IN token after that moves to 100 and raises the interrupt. An IN token before any acknowledgement is a sequence error. In 100, an OUT token is a sequence error and ACK sent returns to 000 with the interrupt.
- R7: In stage 101, an OUT token is a sequence error, an IN token is ignored, and ACK sent returns to 000 with the interrupt.
- R8: An OUT token flagged as exceeding the endpoint-0 packet size is a sequence error in any stage from 001 to 101.
- R9: On a sequence error the stage becomes 110 and the stall output is high. The stall is high only in stage 110 and stays high until a SETUP token leaves that stage.
- R10: If the error enable is high when an error occurs, the interrupt is raised and the error is locked. While locked, SETUP, token and ACK pulses have no effect. A clear pulse unlocks and drops the flag, after which the code stays 110 until a SETUP token arrives.
- R11: If the error enable is low when an error occurs, the error does not raise the interrupt, and a following SETUP token returns the stage to 000.
- R12: The interrupt flag stays set until a clear pulse. If a raising event and a clear happen in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_tok | input | 1 | SETUP token received (pulse) |
| in_tok | input | 1 | IN token received (pulse) |
| out_tok | input | 1 | OUT token with data received (pulse) |
| ack_tx | input | 1 | Device sent ACK (pulse) |
| ack_rx | input | 1 | Host ACK received (pulse) |
| rx_zlp | input | 1 | Received OUT packet was zero-length |
| req_dir_in | input | 1 | Request direction is device-to-host |
| wlen_zero | input | 1 | Request wLength is zero |
| rx_oversize | input | 1 | Received OUT packet exceeded the endpoint-0 size |
| serr_en | input | 1 | Sequence-error interrupt enable |
| ctrt_clr | input | 1 | Software clear of the interrupt flag (pulse) |
| stage_o | output | 3 | Current stage code |
| ctrt_o | output | 1 | Sticky stage-change interrupt flag |
| stall_o | output | 1 | Forced stall of the endpoint-0 handshake |

## Verification
The hardest state to reach is a locked error that then receives a SETUP and a complete setup handshake before firmware clears the flag. Reaching it needs the error enable high at the exact error cycle, followed by traffic that would normally restart the transfer. Directed sequences build this state on purpose and check that the code, flag and stall hold. They then check that the code stays 110 after the clear until a fresh SETUP. Random traffic, with the clear pulse made rare, revisits locked errors many times across all stages and is compared against a bench-side model.

// File: rtl/ctt_pkg.sv
package ctt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'b000,
        ST_RDATA  = 3'b001,
        ST_RSTAT  = 3'b010,
        ST_WDATA  = 3'b011,
        ST_WSTAT  = 3'b100,
        ST_NDSTAT = 3'b101,
        ST_ERR    = 3'b110
    } stage_e;

    // Packed so that the MSB is the highest priority pulse.
    typedef struct packed {
        logic setup;
        logic out;
        logic in;
        logic atx;
        logic arx;
    } evt_t;

    typedef struct packed {
        logic zlp;
        logic dir_in;
        logic wlen_zero;
        logic oversize;
    } qual_t;

    typedef struct packed {
        logic setup_done;
        logic rd_stat;
        logic wr_stat;
        logic done;
        logic seq_err;
    } cause_t;

    localparam int EVT_N   = $bits(evt_t);
    localparam int STAGE_W = $bits(stage_e);

    function automatic stage_e data_stage(input logic dir_in, input logic wz);
        if (dir_in)
            return ST_RDATA;
        else if (wz)
            return ST_NDSTAT;
        else
            return ST_WDATA;
    endfunction

    function automatic logic raises_irq(input cause_t c, input logic serr);
        return c.setup_done | c.rd_stat | c.wr_stat | c.done | (c.seq_err & serr);
    endfunction

    function automatic logic in_transfer(input stage_e s);
        return (s != ST_IDLE) && (s != ST_ERR);
    endfunction

endpackage

// File: rtl/ctt_evt_prio.sv
module ctt_evt_prio
    import ctt_pkg::*;
#(
    parameter int N = EVT_N
) (
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] grant_o
);

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            if (g == N - 1) begin : g_top
                assign grant_o[g] = raw_i[g];
            end else begin : g_low
                assign grant_o[g] = raw_i[g] & ~(|raw_i[N-1:g+1]);
            end
        end
    endgenerate

endmodule

// File: rtl/ctt_stage_fsm.sv
module ctt_stage_fsm
    import ctt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  evt_t   evt_i,
    input  qual_t  qual_i,
    input  logic   lock_i,
    output stage_e stage_o,
    output logic   stall_o,
    output cause_t cause_o
);

    stage_e stage_q, stage_d;
    logic   pend_q, pend_d;
    logic   sent_q, sent_d;
    logic   acked_q, acked_d;
    logic   stall_q, stall_d;
    cause_t cause;
    logic   err;

    always_comb begin
        stage_d = stage_q;
        pend_d  = pend_q;
        sent_d  = sent_q;
        acked_d = acked_q;
        stall_d = stall_q;
        cause   = '0;
        err     = 1'b0;

        if (lock_i) begin
            // frozen until software clears the flag
        end else if (evt_i.setup) begin
            stage_d = ST_IDLE;
            pend_d  = 1'b1;
            stall_d = 1'b0;
        end else begin
            if (evt_i.out && qual_i.oversize && in_transfer(stage_q))
                err = 1'b1;
            else begin
                unique case (stage_q)
                    ST_IDLE: begin
                        if (evt_i.atx && pend_q) begin
                            stage_d          = data_stage(qual_i.dir_in, qual_i.wlen_zero);
                            pend_d           = 1'b0;
                            sent_d           = 1'b0;
                            acked_d          = 1'b0;
                            cause.setup_done = 1'b1;
                        end
                    end
                    ST_RDATA: begin
                        if (evt_i.out) begin
                            if (sent_q) begin
                                stage_d       = ST_RSTAT;
                                cause.rd_stat = 1'b1;
                            end else
                                err = 1'b1;
                        end else if (evt_i.arx)
                            sent_d = 1'b1;
                    end
                    ST_RSTAT: begin
                        if (evt_i.in)
                            err = 1'b1;
                        else if (evt_i.out && !qual_i.zlp)
                            err = 1'b1;
                        else if (evt_i.arx && !evt_i.out) begin
                            stage_d    = ST_IDLE;
                            cause.done = 1'b1;
                        end
                    end
                    ST_WDATA: begin
                        if (evt_i.in) begin
                            if (acked_q) begin
                                stage_d       = ST_WSTAT;
                                cause.wr_stat = 1'b1;
                            end else
                                err = 1'b1;
                        end else if (evt_i.atx && !evt_i.out)
                            acked_d = 1'b1;
                    end
                    ST_WSTAT, ST_NDSTAT: begin
                        if (evt_i.out)
                            err = 1'b1;
                        else if (evt_i.atx && !evt_i.in) begin
                            stage_d    = ST_IDLE;
                            cause.done = 1'b1;
                        end
                    end
                    default: begin
                        // error stage: only SETUP leaves
                    end
                endcase
            end
            if (err) begin
                stage_d       = ST_ERR;
                stall_d       = 1'b1;
                cause         = '0;
                cause.seq_err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= ST_IDLE;
            pend_q  <= 1'b0;
            sent_q  <= 1'b0;
            acked_q <= 1'b0;
            stall_q <= 1'b0;
        end else begin
            stage_q <= stage_d;
            pend_q  <= pend_d;
            sent_q  <= sent_d;
            acked_q <= acked_d;
            stall_q <= stall_d;
        end
    end

    assign stage_o = stage_q;
    assign stall_o = stall_q;
    assign cause_o = cause;

endmodule

// File: rtl/ctt_irq.sv
module ctt_irq
    import ctt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cause_t cause_i,
    input  logic   serr_en,
    input  logic   clr_i,
    output logic   flag_o,
    output logic   lock_o
);

    logic flag_q, lock_q;
    logic set_now;

    assign set_now = raises_irq(cause_i, serr_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            if (set_now)
                flag_q <= 1'b1;
            else if (clr_i)
                flag_q <= 1'b0;

            if (cause_i.seq_err && serr_en)
                lock_q <= 1'b1;
            else if (clr_i)
                lock_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign lock_o = lock_q;

endmodule

// File: rtl/ctrl_xfer_tracker.sv
module ctrl_xfer_tracker
    import ctt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       setup_tok,
    input  logic       in_tok,
    input  logic       out_tok,
    input  logic       ack_tx,
    input  logic       ack_rx,
    input  logic       rx_zlp,
    input  logic       req_dir_in,
    input  logic       wlen_zero,
    input  logic       rx_oversize,
    input  logic       serr_en,
    input  logic       ctrt_clr,
    output logic [2:0] stage_o,
    output logic       ctrt_o,
    output logic       stall_o
);

    evt_t   raw_evt, evt;
    qual_t  qual;
    cause_t cause;
    stage_e stage;
    logic   err_lock;

    assign raw_evt = '{setup: setup_tok, out: out_tok, in: in_tok, atx: ack_tx, arx: ack_rx};
    assign qual    = '{zlp: rx_zlp, dir_in: req_dir_in, wlen_zero: wlen_zero, oversize: rx_oversize};

    ctt_evt_prio #(.N(EVT_N)) u_prio (
        .raw_i   (raw_evt),
        .grant_o (evt)
    );

    ctt_stage_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .evt_i   (evt),
        .qual_i  (qual),
        .lock_i  (err_lock),
        .stage_o (stage),
        .stall_o (stall_o),
        .cause_o (cause)
    );

    ctt_irq u_irq (
        .clk     (clk),
        .rst     (rst),
        .cause_i (cause),
        .serr_en (serr_en),
        .clr_i   (ctrt_clr),
        .flag_o  (ctrt_o),
        .lock_o  (err_lock)
    );

    assign stage_o = stage;

endmodule

// File: rtl/ctt_checker.sv
module ctt_checker (
    input logic       clk,
    input logic       rst,
    input logic       setup_tok,
    input logic       ctrt_clr,
    input logic [2:0] stage_o,
    input logic       ctrt_o,
    input logic       stall_o,
    input logic       lock
);

    AST_NO_RSVD_CODE: assert property (@(posedge clk) disable iff (rst)
        stage_o != 3'b111); // R1

    AST_STALL_ONLY_ERR: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> stage_o == 3'b110); // R9

    AST_SETUP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
        setup_tok && !lock |=> stage_o == 3'b000 && !stall_o); // R3

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (rst)
        lock && !ctrt_clr |=> stage_o == 3'b110 && ctrt_o && stall_o); // R10

    AST_CLR_UNLOCK: assert property (@(posedge clk) disable iff (rst)
        lock && ctrt_clr |=> !lock && !ctrt_o); // R10

    AST_RSTAT_IRQ: assert property (@(posedge clk) disable iff (rst)
        stage_o == 3'b010 && $past(stage_o) != 3'b010 |-> ctrt_o); // R4

    AST_WSTAT_IRQ: assert property (@(posedge clk) disable iff (rst)
        stage_o == 3'b100 && $past(stage_o) != 3'b100 |-> ctrt_o); // R6

endmodule

bind ctrl_xfer_tracker ctt_checker u_ctt_checker (
    .clk       (clk),
    .rst       (rst),
    .setup_tok (setup_tok),
    .ctrt_clr  (ctrt_clr),
    .stage_o   (stage_o),
    .ctrt_o    (ctrt_o),
    .stall_o   (stall_o),
    .lock      (err_lock)
);

// File: tb/test_ctrl_xfer_tracker.sv
`timescale 1ns/1ps
module test_ctrl_xfer_tracker;

    localparam logic [2:0] S_IDLE = 3'd0, S_RD = 3'd1, S_RS = 3'd2, S_WD = 3'd3,
                           S_WS = 3'd4, S_ND = 3'd5, S_ER = 3'd6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic setup_tok = 0, in_tok = 0, out_tok = 0, ack_tx = 0, ack_rx = 0;
    logic rx_zlp = 0, req_dir_in = 0, wlen_zero = 0, rx_oversize = 0;
    logic serr_en = 0, ctrt_clr = 0;
    logic [2:0] stage_o;
    logic ctrt_o, stall_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    logic [2:0] m_stage;
    logic m_pend, m_sent, m_acked, m_lock, m_ctrt, m_stall;

    always #2.5 clk = ~clk;

    ctrl_xfer_tracker i_ctrl_xfer_tracker (
        .clk(clk), .rst(rst), .setup_tok(setup_tok), .in_tok(in_tok), .out_tok(out_tok),
        .ack_tx(ack_tx), .ack_rx(ack_rx), .rx_zlp(rx_zlp), .req_dir_in(req_dir_in),
        .wlen_zero(wlen_zero), .rx_oversize(rx_oversize), .serr_en(serr_en),
        .ctrt_clr(ctrt_clr), .stage_o(stage_o), .ctrt_o(ctrt_o), .stall_o(stall_o)
    );

    function automatic logic [2:0] exp_data_stage(input logic d, input logic wz);
        if (d) return S_RD;
        return wz ? S_ND : S_WD;
    endfunction

    task automatic model_reset();
        m_stage = S_IDLE; m_pend = 0; m_sent = 0; m_acked = 0;
        m_lock = 0; m_ctrt = 0; m_stall = 0;
    endtask

    task automatic model_step();
        logic s, o, i, tx, rx, raise, err;
        s  = setup_tok;
        o  = out_tok & ~s;
        i  = in_tok & ~s & ~o;
        tx = ack_tx & ~s & ~o & ~i;
        rx = ack_rx & ~s & ~o & ~i & ~tx;
        raise = 0; err = 0;
        if (!m_lock) begin
            if (s) begin
                m_stage = S_IDLE; m_pend = 1; m_stall = 0;
            end else if (o && rx_oversize && m_stage != S_IDLE && m_stage != S_ER) begin
                err = 1;
            end else begin
                case (m_stage)
                    S_IDLE: if (tx && m_pend) begin
                        m_stage = exp_data_stage(req_dir_in, wlen_zero);
                        m_pend = 0; m_sent = 0; m_acked = 0; raise = 1;
                    end
                    S_RD: if (o) begin
                        if (m_sent) begin m_stage = S_RS; raise = 1; end else err = 1;
                    end else if (rx) m_sent = 1;
                    S_RS: if (i || (o && !rx_zlp)) err = 1;
                          else if (rx) begin m_stage = S_IDLE; raise = 1; end
                    S_WD: if (i) begin
                        if (m_acked) begin m_stage = S_WS; raise = 1; end else err = 1;
                    end else if (tx) m_acked = 1;
                    S_WS, S_ND: if (o) err = 1;
                          else if (tx) begin m_stage = S_IDLE; raise = 1; end
                    default: ;
                endcase
            end
            if (err) begin
                m_stage = S_ER; m_stall = 1;
                if (serr_en) raise = 1;
            end
        end
        if (raise) m_ctrt = 1;
        else if (ctrt_clr) m_ctrt = 0;
        if (err && serr_en) m_lock = 1;
        else if (ctrt_clr) m_lock = 0;
    endtask

    task automatic compare(input string tag);
        checks++;
        if (stage_o !== m_stage || ctrt_o !== m_ctrt || stall_o !== m_stall) begin
            fails++;
            $display("FAIL %s: stage/ctrt/stall actual=%b/%b/%b expected=%b/%b/%b",
                     tag, stage_o, ctrt_o, stall_o, m_stage, m_ctrt, m_stall);
        end
    endtask

    task automatic step(input logic s, input logic i, input logic o, input logic tx,
                        input logic rx, input logic cl, input string tag);
        setup_tok = s; in_tok = i; out_tok = o; ack_tx = tx; ack_rx = rx; ctrt_clr = cl;
        model_step();
        @(negedge clk);
        compare(tag);
        setup_tok = 0; in_tok = 0; out_tok = 0; ack_tx = 0; ack_rx = 0; ctrt_clr = 0;
    endtask

    task automatic expect_state(input logic [2:0] st, input logic c, input logic sl, input string tag);
        checks++;
        if (stage_o !== st || ctrt_o !== c || stall_o !== sl) begin
            fails++;
            $display("FAIL %s: stage/ctrt/stall actual=%b/%b/%b expected=%b/%b/%b",
                     tag, stage_o, ctrt_o, stall_o, st, c, sl);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        compare("R2 reset state");

        // read transfer
        req_dir_in = 1; rx_zlp = 1;
        step(0,0,0,1,0,0, "R3 ack without setup ignored");
        step(1,0,0,0,0,0, "R3 setup");
        step(0,0,0,1,0,0, "R3 setup done to read data");
        expect_state(S_RD, 1, 0, "R1 read data code");
        step(0,0,0,0,0,1, "R12 clear");
        step(0,1,0,0,0,0, "R4 in token");
        step(0,0,0,0,1,0, "R4 data sent");
        step(0,0,1,0,0,0, "R4 read status entry");
        expect_state(S_RS, 1, 0, "R4 read status");
        step(0,0,0,0,0,1, "R12 clear");
        step(0,0,0,0,1,0, "R4 read complete");

        // write transfer, several OUT packets
        req_dir_in = 0; wlen_zero = 0; rx_zlp = 0;
        step(1,0,0,0,0,1, "R3 setup");
        step(0,0,0,1,0,0, "R3 to write data");
        step(0,0,1,0,0,0, "R6 out1");
        step(0,0,0,1,0,0, "R6 ack1");
        step(0,0,1,0,0,0, "R6 out2 beyond wLength ok");
        step(0,0,0,1,0,0, "R6 ack2");
        step(0,1,0,0,0,1, "R6 write status entry");
        expect_state(S_WS, 1, 0, "R6 write status");
        step(0,0,0,1,0,0, "R6 write complete");

        // no-data
        wlen_zero = 1;
        step(1,0,0,0,0,0, "R3 setup");
        step(0,0,0,1,0,1, "R12 set wins over clear");
        expect_state(S_ND, 1, 0, "R7 no-data code");
        step(0,1,0,0,0,1, "R7 in ignored");
        step(0,0,0,1,0,0, "R7 no-data complete");

        // read error, enable off
        serr_en = 0; req_dir_in = 1;
        step(1,0,0,0,0,0, "R3 setup");
        step(0,0,0,1,0,0, "R3 read");
        step(0,0,0,0,0,1, "R12 clear");
        step(0,0,1,0,0,0, "R4 out before data err");
        expect_state(S_ER, 0, 1, "R11 no irq, stall");
        step(0,1,0,1,1,0, "R9 stays error");
        step(1,0,1,0,0,0, "R11 setup priority leaves error");
        expect_state(S_IDLE, 0, 0, "R11 back to idle");

        // read status errors
        step(0,0,0,1,0,0, "R3"); step(0,0,0,0,1,0, "R4"); rx_zlp = 1;
        step(0,0,1,0,0,0, "R4"); step(0,1,0,0,0,0, "R5 in in status");
        step(1,0,0,0,0,0, "R3"); step(0,0,0,1,0,0, "R3"); step(0,0,0,0,1,0, "R4");
        step(0,0,1,0,0,0, "R4"); rx_zlp = 0;
        step(0,0,1,0,0,0, "R5 nonzero out in status");

        // write errors
        req_dir_in = 0; wlen_zero = 0;
        step(1,0,0,0,0,0, "R3"); step(0,0,0,1,0,0, "R3");
        step(0,1,0,0,0,0, "R6 in before ack");
        step(1,0,0,0,0,0, "R3"); step(0,0,0,1,0,0, "R3"); step(0,0,1,0,0,0, "R6");
        step(0,0,0,1,0,0, "R6"); step(0,1,0,0,0,0, "R6");
        step(0,0,1,0,0,0, "R6 out in write status");
        wlen_zero = 1;
        step(1,0,0,0,0,0, "R3"); step(0,0,0,1,0,0, "R3");
        step(0,0,1,0,0,0, "R7 out in no-data status");
        wlen_zero = 0;
        step(1,0,0,0,0,0, "R3"); step(0,0,0,1,0,0, "R3"); rx_oversize = 1;
        step(0,0,1,0,0,0, "R8 oversize");
        expect_state(S_ER, ctrt_o, 1, "R8 oversize error");
        rx_oversize = 0;

        // locked error
        serr_en = 1;
        step(1,0,0,0,0,1, "R3"); step(0,0,0,1,0,0, "R3"); step(0,0,0,0,0,1, "R12");
        step(0,1,0,0,0,0, "R10 error raises irq");
        expect_state(S_ER, 1, 1, "R10 locked");
        step(1,0,0,0,0,0, "R10 setup ignored");
        step(0,0,0,1,0,0, "R10 ack ignored");
        expect_state(S_ER, 1, 1, "R10 still frozen");
        step(0,0,0,0,0,1, "R10 clear");
        expect_state(S_ER, 0, 1, "R10 holds 110 after clear");
        step(0,0,0,1,0,0, "R10 ack no effect");
        step(1,0,0,0,0,0, "R10 setup leaves");
        expect_state(S_IDLE, 0, 0, "R10 idle after setup");

        // random traffic
        for (int n = 0; n < 6000; n++) begin
            int pick;
            pick = $urandom_range(0, 99);
            rx_zlp      = ($urandom_range(0, 3) != 0);
            req_dir_in  = $urandom_range(0, 1);
            wlen_zero   = ($urandom_range(0, 3) == 0);
            rx_oversize = ($urandom_range(0, 19) == 0);
            serr_en     = ($urandom_range(0, 2) == 0);
            step(pick < 10, pick >= 10 && pick < 28, pick >= 28 && pick < 46,
                 (pick >= 46 && pick < 70) || pick == 99,
                 pick >= 70 && pick < 92, $urandom_range(0, 9) == 0, "R12 random");
        end

        rst = 1; model_reset();
        @(negedge clk);
        compare("R2 reset again");
        finish_run();
    end

endmodule